// File: doc/BRIEF.md
# Shader Control-Flow Sequencer

This block owns the program counter of a small vector shader core and carries out its flow-control instructions. It presents a fetch address to an external program store each cycle and takes back a 32-bit instruction word, whose top six bits are the opcode. Flow opcodes are executed here: jumps, calls, if-blocks (conditional or bool-driven) and counted loops. Every other opcode is treated as arithmetic that is carried out elsewhere, and the PC simply moves on by one. One instruction completes per clock while the block is busy.

Three separate hardware stacks track open loops, open if-blocks and pending call returns. After each instruction the new PC is tested, in a fixed order, against the end address held at the top of each stack, and the PC may be redirected. The sequencer also holds four packed integer uniforms, a 16-bit bool uniform and two address offsets, written through a small register port. It provides the relative-index arithmetic used to address source operands, using those offsets and the running loop counter. The comparison flags come from outside the block.

Top module: `scf_seq`

## Requirements
- R1: After reset, fetch_pc is 0, busy, done and stack_err are 0, loop_ctr is 0, and every uniform and address offset is 0.
- R2: A start pulse while idle loads entry_pc into fetch_pc, raises busy and empties all three stacks. While busy, any opcode other than the flow opcodes listed below advances fetch_pc by 1.
- R3: Opcode 0x22 (END) drops busy and gives a done pulse exactly one cycle long. fetch_pc then holds until the next start.
- R4: Opcode 0x24 (CALL) jumps to the target in bits 21:10 and records a return to PC+1. The return is taken once the PC reaches target + count, where count is in bits 7:0.
- R5: The condition test uses mode bits 23:22, reference x in bit 25 and reference y in bit 24. Mode 0 is true when either flag equals its reference, mode 1 when both do, mode 2 when x does and mode 3 when y does. This test gates opcodes 0x28 (if), 0x25 (call) and 0x2C (jump, taken when true).
- R6: The bool test selects bit (bits 25:22) of the bool uniform. Opcodes 0x27 (if) and 0x26 (call) are gated by that bit being 1. Opcode 0x2D (jump) is taken when that bit equals the inverse of instruction bit 0.
- R7: An if that is false jumps to the target. An if that is true continues at PC+1 and opens a block ending at the target; when the PC reaches that end it moves to target + count.
- R8: Opcode 0x29 (LOOP) reads integer uniform (bits 23:22) and loads loop_ctr with byte 1. Its body runs from PC+1 through the target, byte 0 + 1 times. Each time the PC reaches target+1, byte 2 is added to loop_ctr. The PC goes back to the body start unless the last pass has finished, in which case the loop is closed and execution falls through.
- R9: After each instruction the new PC is tested first against the top loop entry, then against the top if entry using the PC that the loop test produced, and then against the top call entry. A push made by the same instruction already counts as the top.
- R10: Pushing onto a full stack (4 loops, 8 ifs, 4 calls) discards the push and raises stack_err for exactly the following cycle. The instruction's PC change still happens.
- R11: src_index equals src_sel when src_sel is below 0x20 or src_mode is 0. Otherwise it is src_sel plus address offset x (mode 1), offset y (mode 2) or loop_ctr (mode 3), modulo 256.
- R12: Register port addresses 0 to 3 write the integer uniforms, address 4 writes the bool uniform from the low 16 bits, and addresses 5 and 6 write offsets x and y from the low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run at entry_pc (honoured while idle) |
| entry_pc | input | 12 | First PC of a run |
| instr | input | 32 | Instruction word at fetch_pc (same-cycle read) |
| cmp_x | input | 1 | Comparison flag x |
| cmp_y | input | 1 | Comparison flag y |
| cfg_we | input | 1 | Register port write strobe |
| cfg_addr | input | 3 | Register port address |
| cfg_wdata | input | 32 | Register port write data |
| src_sel | input | 7 | Source operand index to be offset |
| src_mode | input | 2 | Relative index mode |
| fetch_pc | output | 12 | Current program counter |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after END |
| stack_err | output | 1 | One-cycle pulse after a push onto a full stack |
| loop_ctr | output | 8 | Loop counter |
| src_index | output | 8 | Offset source operand index |

## Verification
The bench uses the default depths of 4 loops, 8 ifs and 4 calls, so a short run of five nested calls, or nine nested open ifs, reaches the overflow path within a handful of instructions. With the full 12-bit PC, a 256-word program window is enough for forward targets, nested loops and calls whose end addresses land on shared PCs. That makes the ordering of loop, if and call tests visible at the fetch address. Random programs are run in lockstep against a bench model of the instruction semantics, under random flags and uniforms.

// File: rtl/scf_pkg.sv
// Shared constants and stack-entry types of the shader control-flow sequencer.
// Assumes a 32-bit instruction word with the opcode in its top six bits.
package scf_pkg;
    localparam int PC_W    = 12;
    localparam int INSN_W  = 32;
    localparam int CNT_W   = 8;
    localparam int ITER_W  = CNT_W + 1;
    localparam int BOOL_W  = 16;
    localparam int BSEL_W  = $clog2(BOOL_W);
    localparam int NUM_INT = 4;
    localparam int SRC_W   = 7;

    localparam logic [5:0] OP_END   = 6'h22;
    localparam logic [5:0] OP_CALL  = 6'h24;
    localparam logic [5:0] OP_CALLC = 6'h25;
    localparam logic [5:0] OP_CALLU = 6'h26;
    localparam logic [5:0] OP_IFU   = 6'h27;
    localparam logic [5:0] OP_IFC   = 6'h28;
    localparam logic [5:0] OP_LOOP  = 6'h29;
    localparam logic [5:0] OP_JMPC  = 6'h2C;
    localparam logic [5:0] OP_JMPU  = 6'h2D;

    typedef struct packed {
        logic [PC_W-1:0]   start;
        logic [PC_W-1:0]   stop;
        logic [ITER_W-1:0] iters;
        logic [CNT_W-1:0]  step;
    } loop_ent_t;

    typedef struct packed {
        logic [PC_W-1:0] stop;
        logic [PC_W-1:0] resume;
    } if_ent_t;

    typedef struct packed {
        logic [PC_W-1:0] stop;
        logic [PC_W-1:0] ret;
    } call_ent_t;
endpackage

// File: rtl/scf_stack.sv
// Generic LIFO for control-flow entries with push, pop and top rewrite.
// The top it shows already includes a push made in the same cycle, so the
// caller can test an entry it is creating. Push on full is dropped and flagged.
// Assumes pop and upd are only raised while nonempty_eff is high.
module scf_stack #(
    parameter int W     = 24,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         upd,
    input  logic [W-1:0] upd_data,
    output logic [W-1:0] top_eff,
    output logic         nonempty_eff,
    output logic         overflow
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_eff;
    logic          full;
    logic          push_ok;

    // Effective pointer and top after an accepted push
    always_comb begin
        full         = (ptr == PW'(DEPTH));
        push_ok      = push_req && !full;
        overflow     = push_req && full;
        ptr_eff      = ptr + PW'(push_ok);
        nonempty_eff = (ptr_eff != '0);
        top_eff      = push_ok ? push_data : mem[AW'(ptr - 1'b1)];
    end

    // Stack pointer: clear, pop or settle at the effective depth
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (clear)  ptr <= '0;
        else if (pop)    ptr <= ptr_eff - 1'b1;
        else             ptr <= ptr_eff;
    end

    // Entry storage: write a new entry or a rewritten top
    always_ff @(posedge clk) begin
        if (rst_n && !clear && !pop && (push_ok || upd))
            mem[AW'(ptr_eff - 1'b1)] <= upd ? upd_data : push_data;
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(DEPTH)) else $error("stack pointer beyond depth"); // R10
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop && !clear) |=> $stable(ptr)) else $error("push on full moved pointer"); // R10
endmodule

// File: rtl/scf_cond.sv
// Evaluates the two-flag condition test of conditional flow opcodes.
// Purely combinational; mode encoding is fixed by the instruction format.
module scf_cond (
    input  logic [1:0] mode,
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic       cmp_x,
    input  logic       cmp_y,
    output logic       hit
);
    logic mx, my;

    // Match each flag against its reference and combine per mode
    always_comb begin
        mx = (cmp_x == ref_x);
        my = (cmp_y == ref_y);
        unique case (mode)
            2'd0:    hit = mx || my;
            2'd1:    hit = mx && my;
            2'd2:    hit = mx;
            default: hit = my;
        endcase
    end
endmodule

// File: rtl/scf_index.sv
// Relative source-operand indexing: adds an address offset or the loop
// counter to indices at or above the uniform base. Combinational.
module scf_index #(
    parameter int SW   = 7,
    parameter int OW   = 8,
    parameter int BASE = 32
) (
    input  logic [SW-1:0] src,
    input  logic [1:0]    mode,
    input  logic [OW-1:0] off_x,
    input  logic [OW-1:0] off_y,
    input  logic [OW-1:0] ctr,
    output logic [OW-1:0] idx
);
    logic [OW-1:0] off;

    // Pick the offset for the mode and add it above the base
    always_comb begin
        unique case (mode)
            2'd1:    off = off_x;
            2'd2:    off = off_y;
            2'd3:    off = ctr;
            default: off = '0;
        endcase
        if (src < SW'(BASE)) idx = OW'(src);
        else                 idx = OW'(src) + off;
    end
endmodule

// File: rtl/scf_seq.sv
// Shader control-flow sequencer: owns the PC, executes flow opcodes, keeps
// loop/if/call stacks and resolves their end addresses in the order loop, if,
// call after every instruction. Assumes instr is the word at fetch_pc in the
// same cycle, and that non-flow opcodes are executed elsewhere.
module scf_seq
    import scf_pkg::*;
#(
    parameter int LOOP_DEPTH = 4,
    parameter int IF_DEPTH   = 8,
    parameter int CALL_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PC_W-1:0]   entry_pc,
    input  logic [INSN_W-1:0] instr,
    input  logic              cmp_x,
    input  logic              cmp_y,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [SRC_W-1:0]  src_sel,
    input  logic [1:0]        src_mode,
    output logic [PC_W-1:0]   fetch_pc,
    output logic              busy,
    output logic              done,
    output logic              stack_err,
    output logic [CNT_W-1:0]  loop_ctr,
    output logic [CNT_W-1:0]  src_index
);
    logic [PC_W-1:0]   pc;
    logic              running;
    logic              done_q, err_q;
    logic [CNT_W-1:0]  ctr;
    logic [31:0]       int_u [NUM_INT];
    logic [BOOL_W-1:0] bool_u;
    logic [CNT_W-1:0]  off_x, off_y;

    logic [5:0]        op;
    logic [PC_W-1:0]   tgt, pc_seq;
    logic [CNT_W-1:0]  cnt;
    logic              cond_ok, bool_bit, is_end, launch;
    logic [31:0]       lu;

    logic              l_push, i_push, c_push;
    loop_ent_t         l_pdata, l_top, l_udata;
    if_ent_t           i_pdata, i_top;
    call_ent_t         c_pdata, c_top;
    logic              l_ne, i_ne, c_ne;
    logic              l_ovf, i_ovf, c_ovf;
    logic              l_hit, l_pop, l_upd, i_hit, c_hit;
    logic [PC_W-1:0]   pc1, pc2, pc3, pc4;
    logic [CNT_W-1:0]  ctr_base, ctr_n;
    logic              unused_bits;

    assign op       = instr[31:26];
    assign tgt      = instr[21:10];
    assign cnt      = instr[CNT_W-1:0];
    assign pc_seq   = pc + PC_W'(1);
    assign bool_bit = bool_u[instr[25:22]];
    assign lu       = int_u[instr[23:22]];
    assign launch   = start && !running;
    assign unused_bits = ^{instr[9:8], lu[31:24], cfg_wdata[31:16]};

    scf_cond u_cond (
        .mode(instr[23:22]), .ref_x(instr[25]), .ref_y(instr[24]),
        .cmp_x(cmp_x), .cmp_y(cmp_y), .hit(cond_ok)
    );

    // Decode the instruction: sequential PC, branch target and stack pushes
    always_comb begin
        pc1    = pc_seq;
        is_end = 1'b0;
        l_push = 1'b0;
        i_push = 1'b0;
        c_push = 1'b0;
        l_pdata.start  = pc_seq;
        l_pdata.stop   = tgt + PC_W'(1);
        l_pdata.iters  = {1'b0, lu[CNT_W-1:0]} + ITER_W'(1);
        l_pdata.step   = lu[3*CNT_W-1:2*CNT_W];
        i_pdata.stop   = tgt;
        i_pdata.resume = tgt + PC_W'(cnt);
        c_pdata.stop   = tgt + PC_W'(cnt);
        c_pdata.ret    = pc_seq;
        if (running) begin
            unique case (op)
                OP_END:   is_end = 1'b1;
                OP_CALL:  begin c_push = 1'b1; pc1 = tgt; end
                OP_CALLC: if (cond_ok)  begin c_push = 1'b1; pc1 = tgt; end
                OP_CALLU: if (bool_bit) begin c_push = 1'b1; pc1 = tgt; end
                OP_IFC:   if (cond_ok)  i_push = 1'b1; else pc1 = tgt;
                OP_IFU:   if (bool_bit) i_push = 1'b1; else pc1 = tgt;
                OP_LOOP:  l_push = 1'b1;
                OP_JMPC:  if (cond_ok) pc1 = tgt;
                OP_JMPU:  if (bool_bit == !instr[0]) pc1 = tgt;
                default:  ;
            endcase
        end
    end

    // Resolve stack ends in priority order: loop, then if, then call
    always_comb begin
        l_hit   = running && !is_end && l_ne && (pc1 == l_top.stop);
        l_pop   = l_hit && (l_top.iters == ITER_W'(1));
        l_upd   = l_hit && !l_pop;
        l_udata = l_top;
        l_udata.iters = l_top.iters - ITER_W'(1);
        pc2     = l_upd ? l_top.start : pc1;
        i_hit   = running && !is_end && i_ne && (pc2 == i_top.stop);
        pc3     = i_hit ? i_top.resume : pc2;
        c_hit   = running && !is_end && c_ne && (pc3 == c_top.stop);
        pc4     = c_hit ? c_top.ret : pc3;
        ctr_base = l_push ? lu[2*CNT_W-1:CNT_W] : ctr;
        ctr_n    = ctr_base + (l_hit ? l_top.step : '0);
    end

    scf_stack #(.W($bits(loop_ent_t)), .DEPTH(LOOP_DEPTH)) u_lstk (
        .clk(clk), .rst_n(rst_n), .clear(launch), .push_req(l_push), .push_data(l_pdata),
        .pop(l_pop), .upd(l_upd), .upd_data(l_udata), .top_eff(l_top),
        .nonempty_eff(l_ne), .overflow(l_ovf)
    );
    scf_stack #(.W($bits(if_ent_t)), .DEPTH(IF_DEPTH)) u_istk (
        .clk(clk), .rst_n(rst_n), .clear(launch), .push_req(i_push), .push_data(i_pdata),
        .pop(i_hit), .upd(1'b0), .upd_data(i_pdata), .top_eff(i_top),
        .nonempty_eff(i_ne), .overflow(i_ovf)
    );
    scf_stack #(.W($bits(call_ent_t)), .DEPTH(CALL_DEPTH)) u_cstk (
        .clk(clk), .rst_n(rst_n), .clear(launch), .push_req(c_push), .push_data(c_pdata),
        .pop(c_hit), .upd(1'b0), .upd_data(c_pdata), .top_eff(c_top),
        .nonempty_eff(c_ne), .overflow(c_ovf)
    );

    // Run control: launch, per-instruction PC/counter update, END halt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; running <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; ctr <= '0;
        end else begin
            done_q <= running && is_end;
            err_q  <= l_ovf || i_ovf || c_ovf;
            if (launch) begin
                pc <= entry_pc; running <= 1'b1;
            end else if (running) begin
                if (is_end) running <= 1'b0;
                else begin pc <= pc4; ctr <= ctr_n; end
            end
        end
    end

    // Register port: integer and bool uniforms and the two address offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_INT; k++) int_u[k] <= '0;
            bool_u <= '0; off_x <= '0; off_y <= '0;
        end else if (cfg_we) begin
            if (cfg_addr < 3'(NUM_INT)) int_u[cfg_addr[1:0]] <= cfg_wdata;
            else if (cfg_addr == 3'd4)  bool_u <= cfg_wdata[BOOL_W-1:0];
            else if (cfg_addr == 3'd5)  off_x  <= cfg_wdata[CNT_W-1:0];
            else if (cfg_addr == 3'd6)  off_y  <= cfg_wdata[CNT_W-1:0];
        end
    end

    scf_index #(.SW(SRC_W), .OW(CNT_W), .BASE(32)) u_idx (
        .src(src_sel), .mode(src_mode), .off_x(off_x), .off_y(off_y),
        .ctr(ctr), .idx(src_index)
    );

    assign fetch_pc  = pc;
    assign busy      = running;
    assign done      = done_q;
    assign stack_err = err_q;
    assign loop_ctr  = ctr;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(fetch_pc)) else $error("pc moved while idle"); // R3
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && fetch_pc == $past(entry_pc))) else $error("start not taken"); // R2
    AST_LOW_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel < 7'h20) |-> (src_index == {1'b0, src_sel})) else $error("low index offset"); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |-> $past(busy)) else $error("stack error while idle"); // R10
endmodule

// File: tb/scf_seq_test.sv
// Lockstep bench: a behavioural model of the flow opcodes predicts fetch_pc,
// loop_ctr, stack_err, done and busy every cycle.
module scf_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] E_END = 6'h22, E_CALL = 6'h24, E_CALLC = 6'h25, E_CALLU = 6'h26,
                           E_IFU = 6'h27, E_IFC = 6'h28, E_LOOP = 6'h29, E_JMPC = 6'h2C,
                           E_JMPU = 6'h2D;

    logic clk = 0, rst_n = 0, start = 0;
    logic [11:0] entry_pc = 0;
    logic [31:0] instr;
    logic cmp_x = 0, cmp_y = 0, cfg_we = 0;
    logic [2:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [6:0] src_sel = 0;
    logic [1:0] src_mode = 0;
    logic [11:0] fetch_pc;
    logic busy, done, stack_err;
    logic [7:0] loop_ctr, src_index;

    logic [31:0] pmem [256];
    assign instr = pmem[fetch_pc[7:0]];

    scf_seq uut (.clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc), .instr(instr),
        .cmp_x(cmp_x), .cmp_y(cmp_y), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .src_sel(src_sel), .src_mode(src_mode), .fetch_pc(fetch_pc), .busy(busy), .done(done),
        .stack_err(stack_err), .loop_ctr(loop_ctr), .src_index(src_index));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    logic [31:0] m_iu [4];
    logic [15:0] m_bool;
    logic [7:0]  m_ax, m_ay, m_ctr;
    logic [11:0] m_pc;
    logic m_err, m_done, m_run;
    logic [11:0] ls_start [4], ls_end [4];
    int          ls_it [4];
    logic [7:0]  ls_inc [4];
    logic [11:0] is_end [8], is_res [8];
    logic [11:0] cs_end [4], cs_ret [4];
    int lp, ip, cp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [3:0] hi,
                                       input logic [11:0] tg, input logic [7:0] nm);
        return {op, hi, tg, 2'b00, nm};
    endfunction

    function automatic bit cond_ref(input logic [1:0] md, input bit rx, input bit ry,
                                    input bit cx, input bit cy);
        case (md)
            2'd0: return (cx == rx) || (cy == ry);
            2'd1: return (cx == rx) && (cy == ry);
            2'd2: return cx == rx;
            default: return cy == ry;
        endcase
    endfunction

    function automatic logic [7:0] idx_ref(input logic [6:0] s, input logic [1:0] md);
        if (s < 7'h20) return {1'b0, s};
        case (md)
            2'd1: return {1'b0, s} + m_ax;
            2'd2: return {1'b0, s} + m_ay;
            2'd3: return {1'b0, s} + m_ctr;
            default: return {1'b0, s};
        endcase
    endfunction

    task automatic model_step();
        logic [31:0] w, u;
        logic [5:0] op;
        logic [3:0] hi;
        logic [11:0] tg, np;
        logic [7:0] nm;
        bit cv, bb, pc_ok, pi_ok, pl_ok;
        w = pmem[m_pc[7:0]];
        op = w[31:26]; hi = w[25:22]; tg = w[21:10]; nm = w[7:0];
        np = m_pc + 12'd1; m_err = 0; m_done = 0;
        cv = cond_ref(hi[1:0], hi[3], hi[2], cmp_x, cmp_y);
        bb = m_bool[hi];
        pc_ok = 0; pi_ok = 0; pl_ok = 0;
        if (op == E_END) begin m_done = 1; m_run = 0; return; end
        case (op)
            E_CALL:  begin pc_ok = 1; np = tg; end
            E_CALLC: if (cv) begin pc_ok = 1; np = tg; end
            E_CALLU: if (bb) begin pc_ok = 1; np = tg; end
            E_IFC:   if (cv) pi_ok = 1; else np = tg;
            E_IFU:   if (bb) pi_ok = 1; else np = tg;
            E_LOOP:  pl_ok = 1;
            E_JMPC:  if (cv) np = tg;
            E_JMPU:  if (bb == !w[0]) np = tg;
            default: ;
        endcase
        if (pc_ok) begin
            if (cp == 4) m_err = 1;
            else begin cs_end[cp] = tg + 12'(nm); cs_ret[cp] = m_pc + 12'd1; cp++; end
        end
        if (pi_ok) begin
            if (ip == 8) m_err = 1;
            else begin is_end[ip] = tg; is_res[ip] = tg + 12'(nm); ip++; end
        end
        if (pl_ok) begin
            u = m_iu[hi[1:0]];
            m_ctr = u[15:8];
            if (lp == 4) m_err = 1;
            else begin
                ls_start[lp] = np; ls_end[lp] = tg + 12'd1;
                ls_it[lp] = int'(u[7:0]) + 1; ls_inc[lp] = u[23:16]; lp++;
            end
        end
        if (lp > 0 && np == ls_end[lp-1]) begin
            ls_it[lp-1]--;
            m_ctr = m_ctr + ls_inc[lp-1];
            if (ls_it[lp-1] == 0) lp--;
            else np = ls_start[lp-1];
        end
        if (ip > 0 && np == is_end[ip-1]) begin np = is_res[ip-1]; ip--; end
        if (cp > 0 && np == cs_end[cp-1]) begin np = cs_ret[cp-1]; cp--; end
        m_pc = np;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; start = 0; cfg_we = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        for (int k = 0; k < 4; k++) m_iu[k] = 0;
        m_bool = 0; m_ax = 0; m_ay = 0; m_ctr = 0; m_pc = 0;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
        if (a < 4) m_iu[a[1:0]] = d;
        else if (a == 4) m_bool = d[15:0];
        else if (a == 5) m_ax = d[7:0];
        else if (a == 6) m_ay = d[7:0];
    endtask

    task automatic clear_prog();
        for (int k = 0; k < 256; k++) pmem[k] = {6'h01, 26'h0};
    endtask

    task automatic run_prog(input logic [11:0] e, input int max_steps, input string tag);
        @(negedge clk); start = 1; entry_pc = e;
        @(negedge clk); start = 0;
        m_pc = e; lp = 0; ip = 0; cp = 0; m_err = 0; m_done = 0; m_run = 1;
        for (int s = 0; s < max_steps; s++) begin
            chk(fetch_pc == m_pc, tag, fetch_pc, m_pc);
            chk(loop_ctr == m_ctr, tag, loop_ctr, m_ctr);
            chk(stack_err == m_err, tag, stack_err, m_err);
            chk(done == m_done, tag, done, m_done);
            chk(busy == m_run, tag, busy, m_run);
            if (!m_run) break;
            model_step();
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL R2 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        clear_prog();
        do_reset();
        // R1: reset state at the ports
        chk(fetch_pc == 0, "R1", fetch_pc, 0);
        chk(busy == 0, "R1", busy, 0);
        chk(done == 0 && stack_err == 0, "R1", {done, stack_err}, 0);
        chk(loop_ctr == 0, "R1", loop_ctr, 0);
        src_sel = 7'h45; src_mode = 2'd1; #1;
        chk(src_index == 8'h45, "R1", src_index, 8'h45);

        // R8 R4 R12: loop of three passes over a body that makes a call
        clear_prog();
        pmem[1]  = mk(E_LOOP, 4'b0011, 12'd3, 8'd0);
        pmem[2]  = mk(E_CALL, 4'b0000, 12'd10, 8'd2);
        pmem[4]  = mk(E_END, 4'b0, 12'd0, 8'd0);
        cfg_write(3, 32'h0002_0502);
        run_prog(12'd0, 100, "R8");
        chk(loop_ctr == 8'd11, "R8", loop_ctr, 11);
        chk(fetch_pc == 12'd4, "R3", fetch_pc, 4);
        // R3: idle hold after END
        repeat (3) @(negedge clk);
        chk(fetch_pc == 12'd4 && done == 0 && busy == 0, "R3", {busy, done, fetch_pc}, 4);

        // R11 R12: relative operand indexing with loop_ctr = 11
        cfg_write(5, 32'hFFFF_FF05);
        cfg_write(6, 32'h0000_00F0);
        src_sel = 7'h1F; src_mode = 2'd1; #1;
        chk(src_index == 8'h1F, "R11", src_index, 8'h1F);
        src_sel = 7'h20; src_mode = 2'd1; #1;
        chk(src_index == 8'h25, "R11", src_index, 8'h25);
        for (int k = 0; k < 24; k++) begin
            src_sel = 7'($urandom); src_mode = 2'($urandom); #1;
            chk(src_index == idx_ref(src_sel, src_mode), "R11", src_index, idx_ref(src_sel, src_mode));
        end

        // R9 R6 R7: loop end and if end share a PC
        do_reset(); clear_prog();
        pmem[0] = mk(E_LOOP, 4'b0001, 12'd2, 8'd0);
        pmem[1] = mk(E_IFU, 4'd3, 12'd3, 8'd2);
        pmem[5] = mk(E_END, 4'b0, 12'd0, 8'd0);
        cfg_write(1, 32'h0001_0001);
        cfg_write(4, 32'h0000_0008);
        run_prog(12'd0, 100, "R9");
        chk(fetch_pc == 12'd5, "R9", fetch_pc, 5);
        // R7: false bool-if jumps straight to its target
        cfg_write(4, 32'h0000_0000);
        run_prog(12'd0, 100, "R7");

        // R10: fifth nested call and ninth nested if overflow
        do_reset(); clear_prog();
        for (int k = 0; k < 5; k++) pmem[k] = mk(E_CALL, 4'b0, 12'(k + 1), 8'd100);
        for (int k = 5; k < 14; k++) pmem[k] = mk(E_IFU, 4'd0, 12'd200, 8'd1);
        pmem[14] = mk(E_END, 4'b0, 12'd0, 8'd0);
        cfg_write(4, 32'h0000_0001);
        run_prog(12'd0, 100, "R10");
        @(negedge clk); start = 1; entry_pc = 0;
        @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        chk(stack_err == 1, "R10", stack_err, 1);
        @(negedge clk);
        chk(stack_err == 0, "R10", stack_err, 0);

        // R5 R6: every condition mode and bool bit, all flag combinations
        do_reset(); clear_prog();
        for (int k = 0; k < 16; k++) begin
            pmem[2*k]      = mk(E_JMPC, 4'(k), 12'(2*k + 2), 8'd0);
            pmem[32 + 2*k] = mk(E_JMPU, 4'(k), 12'(34 + 2*k), 8'(k));
        end
        pmem[64] = mk(E_END, 4'b0, 12'd0, 8'd0);
        cfg_write(4, 32'h0000_A5C3);
        for (int f = 0; f < 4; f++) begin
            cmp_x = f[0]; cmp_y = f[1];
            run_prog(12'd0, 200, "R5");
        end
        clear_prog();
        pmem[0] = mk(E_CALLC, 4'b1001, 12'd6, 8'd1);
        pmem[1] = mk(E_IFC, 4'b0110, 12'd9, 8'd3);
        pmem[2] = mk(E_CALLU, 4'd7, 12'd20, 8'd2);
        pmem[3] = mk(E_END, 4'b0, 12'd0, 8'd0);
        pmem[12] = mk(E_END, 4'b0, 12'd0, 8'd0);
        for (int f = 0; f < 4; f++) begin
            cmp_x = f[0]; cmp_y = f[1];
            run_prog(12'd0, 200, "R6");
        end

        // R2 R4 R9 R10: random programs in lockstep
        for (int r = 0; r < 30; r++) begin
            do_reset();
            for (int k = 0; k < 4; k++)
                cfg_write(3'(k), {8'($urandom), 8'($urandom % 5), 8'($urandom), 8'($urandom % 4)});
            cfg_write(4, $urandom);
            cmp_x = 1'($urandom); cmp_y = 1'($urandom);
            for (int i = 0; i < 256; i++) begin
                int sel;
                logic [5:0] op;
                sel = $urandom % 100;
                if (sel < 60) op = 6'($urandom % 32);
                else if (sel > 97) op = E_END;
                else begin
                    case ($urandom % 8)
                        0: op = E_CALL;  1: op = E_CALLC; 2: op = E_CALLU; 3: op = E_IFU;
                        4: op = E_IFC;   5: op = E_LOOP;  6: op = E_JMPC;  default: op = E_JMPU;
                    endcase
                end
                pmem[i] = mk(op, 4'($urandom), 12'(i + 1 + ($urandom % 12)), 8'(1 + $urandom % 6));
            end
            run_prog(12'($urandom % 16), 300, "R2");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule